// File: doc/BRIEF.md
# Adaptive Update-to-Invalidate Line Controller

This block holds the coherence state of a small set of cache lines under a hybrid protocol. Copies are normally kept fresh by taking every write broadcast that another cache places on the bus. Each line carries a small idle counter. It is loaded to a threshold when the line is filled, and again on every local read or write. Each snooped update counts it down. The counter is how a copy that is no longer used drops out of the update traffic, so that the last active writer can own the line privately.

Two policies are available through a mode input. In immediate mode, a copy whose counter is already zero invalidates itself on the next snooped update. In deferred mode, a copy keeps taking updates but drives the wired-OR shared line only while its count after the update is non-zero. When a foreign update finishes with the shared line low, every idle copy invalidates itself. On the writing side, a local write to a shared copy requests a bus update. When that update completes with the shared line low, the writer moves to a private modified state, and its further writes stay local. Bus arbitration and the data array lie outside the block; the data array latches bus data using the per-line update enables.

Each line runs a four-state machine:
- INVALID: no copy.
- SHARED: a valid copy that takes updates.
- AWAIT: the line's own update is on the bus.
- MODIFIED: a private copy whose writes stay local.

Its transitions are:
- fill: any state to SHARED.
- write-hit: SHARED to AWAIT, raising the bus request.
- own-done shared: AWAIT to SHARED.
- own-done private: AWAIT to MODIFIED.
- snoop-downgrade: MODIFIED to SHARED.
- idle-kill: SHARED, AWAIT or MODIFIED to INVALID, in immediate mode.
- deferred-kill: SHARED to INVALID, on a foreign completion.

Top module: `upd_inv_ctrl`

## Requirements
- R1: After reset every line is INVALID, and shared_out, bus_upd_req, upd_en and inval are all low.
- R2: A fill makes the line valid and not modified, and loads its counter with THRESH. A snoop or reference to the same line in the fill cycle has no effect: no update enable and no shared assertion.
- R3: Each snooped update to a valid line decrements its counter, saturating at zero. In deferred mode (cfg_defer=1), shared_out is high in the snoop cycle only if the decremented value is non-zero.
- R4: A local read or write to a valid line reloads the counter to THRESH. A reload in the same cycle as a snoop to that line wins over the decrement, so that snoop neither invalidates the line nor drops shared_out.
- R5: In immediate mode (cfg_defer=0), a snoop to a line whose counter is zero, with no reference that cycle, pulses inval for that line in that cycle. No update enable is raised, and the line is INVALID from the next cycle.
- R6: In immediate mode, a snooped copy that survives drives shared_out high in that cycle.
- R7: A snoop that does not invalidate a valid line raises exactly that line's bit of upd_en in the snoop cycle. A snoop to an INVALID line raises no output.
- R8: In deferred mode, a foreign completion (done_own=0) with shared_in low invalidates the named SHARED line if its counter is zero, pulsing inval. A completion with shared_in high, or one that finds a non-zero counter, changes nothing.
- R9: A local write to a SHARED line raises bus_upd_req in that cycle and enters AWAIT. An own completion (done_own=1) with shared_in low makes the line MODIFIED. With shared_in high the line returns to SHARED.
- R10: A local write to a MODIFIED line raises no bus_upd_req.
- R11: A reference to an INVALID line is ignored. A snoop to a MODIFIED line takes the data and returns the line to SHARED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_defer | input | 1 | 1 selects deferred invalidation, 0 immediate |
| fill_vld | input | 1 | Line fill this cycle |
| fill_idx | input | IDX_W | Line being filled |
| ref_vld | input | 1 | Local read or write reference |
| ref_idx | input | IDX_W | Line referenced |
| ref_write | input | 1 | 1 for a write reference |
| snp_vld | input | 1 | Snooped foreign bus update |
| snp_idx | input | IDX_W | Line matched by the snoop |
| done_vld | input | 1 | Bus update completion with sampled shared line |
| done_idx | input | IDX_W | Line of the completed update |
| done_own | input | 1 | 1 if the completed update was this cache's own |
| shared_in | input | 1 | Sampled wired-OR shared line at completion |
| shared_out | output | 1 | This cache's drive onto the shared line |
| bus_upd_req | output | 1 | Request to broadcast the local write |
| upd_en | output | NUM_LINES | Per-line enable to take the bus data |
| inval | output | NUM_LINES | Per-line invalidation pulse |
| line_vld | output | NUM_LINES | Line holds a copy |
| line_mod | output | NUM_LINES | Line is privately modified |

## Verification
The hardest case to reach from the ports is a snoop that finds a counter at zero while a local reference lands in the same cycle. Only the priority of the reload then decides whether the line survives. The stimulus gets there by walking a line down through exactly THRESH snoops, then issuing the fourth snoop together with a read. It then proves that the reload took effect by counting the further snoops the line survives before it dies. Deferred mode is driven to the same zero-count edge, and the completion is given first with the shared line high and then low. This separates the two deferred outcomes.

// File: rtl/upd_inv_pkg.sv
package upd_inv_pkg;
    typedef enum logic [1:0] {
        LN_INVALID  = 2'd0,
        LN_SHARED   = 2'd1,
        LN_AWAIT    = 2'd2,
        LN_MODIFIED = 2'd3
    } line_state_e;
endpackage

// File: rtl/upd_inv_onehot.sv
module upd_inv_onehot #(
    parameter int NUM_LINES = 4,
    parameter int IDX_W     = 2
) (
    input  logic                 vld,
    input  logic [IDX_W-1:0]     idx,
    output logic [NUM_LINES-1:0] hot
);
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_dec
        assign hot[g] = vld && (idx == IDX_W'(g));
    end
endmodule

// File: rtl/upd_inv_cnt.sv
module upd_inv_cnt #(
    parameter int THRESH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic dec,
    output logic is_zero,
    output logic le_one
);
    localparam int CW = $clog2(THRESH + 1);

    logic [CW-1:0] cnt_q;

    // Reload wins over decrement; decrement saturates at zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(THRESH);
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign is_zero = (cnt_q == '0);
    assign le_one  = (cnt_q <= CW'(1));
endmodule

// File: rtl/upd_inv_line.sv
module upd_inv_line
    import upd_inv_pkg::*;
#(
    parameter int THRESH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_defer,
    input  logic fill_hit,
    input  logic ref_hit,
    input  logic ref_wr,
    input  logic snp_hit,
    input  logic fdone_hit,
    input  logic odone_hit,
    input  logic shared_in,
    output logic upd_en,
    output logic inval,
    output logic shr,
    output logic bus_req,
    output logic vld,
    output logic modf
);
    line_state_e state_q, state_d;
    logic cnt_zero, cnt_le1;
    logic valid, snp_eff, ref_eff, imm_kill, def_kill;

    assign valid   = (state_q != LN_INVALID);
    assign snp_eff = snp_hit && valid && !fill_hit;
    assign ref_eff = ref_hit && valid && !fill_hit;

    upd_inv_cnt #(.THRESH(THRESH)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (fill_hit || ref_eff),
        .dec     (snp_eff),
        .is_zero (cnt_zero),
        .le_one  (cnt_le1)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LN_INVALID;
        else        state_q <= state_d;
    end

    // Kill conditions
    always_comb begin
        imm_kill = snp_eff && !cfg_defer && cnt_zero && !ref_eff;
        def_kill = fdone_hit && cfg_defer && !shared_in && (state_q == LN_SHARED)
                   && cnt_zero && !ref_eff && !fill_hit;
    end

    // Outputs
    always_comb begin
        upd_en  = snp_eff && !imm_kill;
        inval   = imm_kill || def_kill;
        shr     = snp_eff && !imm_kill && (!cfg_defer || ref_eff || !cnt_le1);
        bus_req = ref_eff && ref_wr && ((state_q == LN_SHARED) || (state_q == LN_AWAIT));
        vld     = valid;
        modf    = (state_q == LN_MODIFIED);
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (fill_hit) begin
            state_d = LN_SHARED;
        end else begin
            unique case (state_q)
                LN_INVALID: state_d = LN_INVALID;
                LN_SHARED: begin
                    if (imm_kill || def_kill)  state_d = LN_INVALID;
                    else if (bus_req)          state_d = LN_AWAIT;
                end
                LN_AWAIT: begin
                    if (imm_kill)              state_d = LN_INVALID;
                    else if (odone_hit)        state_d = shared_in ? LN_SHARED : LN_MODIFIED;
                end
                LN_MODIFIED: begin
                    if (imm_kill)              state_d = LN_INVALID;
                    else if (snp_eff)          state_d = LN_SHARED;
                end
                default: state_d = LN_INVALID;
            endcase
        end
    end
endmodule

// File: rtl/upd_inv_ctrl.sv
module upd_inv_ctrl #(
    parameter int NUM_LINES = 4,
    parameter int THRESH    = 3,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_defer,
    input  logic                 fill_vld,
    input  logic [IDX_W-1:0]     fill_idx,
    input  logic                 ref_vld,
    input  logic [IDX_W-1:0]     ref_idx,
    input  logic                 ref_write,
    input  logic                 snp_vld,
    input  logic [IDX_W-1:0]     snp_idx,
    input  logic                 done_vld,
    input  logic [IDX_W-1:0]     done_idx,
    input  logic                 done_own,
    input  logic                 shared_in,
    output logic                 shared_out,
    output logic                 bus_upd_req,
    output logic [NUM_LINES-1:0] upd_en,
    output logic [NUM_LINES-1:0] inval,
    output logic [NUM_LINES-1:0] line_vld,
    output logic [NUM_LINES-1:0] line_mod
);
    logic [NUM_LINES-1:0] fill_hot, ref_hot, snp_hot, done_hot;
    logic [NUM_LINES-1:0] shr_vec, req_vec;

    upd_inv_onehot #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_dec_fill (
        .vld(fill_vld), .idx(fill_idx), .hot(fill_hot));
    upd_inv_onehot #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_dec_ref (
        .vld(ref_vld), .idx(ref_idx), .hot(ref_hot));
    upd_inv_onehot #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_dec_snp (
        .vld(snp_vld), .idx(snp_idx), .hot(snp_hot));
    upd_inv_onehot #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_dec_done (
        .vld(done_vld), .idx(done_idx), .hot(done_hot));

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        upd_inv_line #(.THRESH(THRESH)) u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_defer (cfg_defer),
            .fill_hit  (fill_hot[g]),
            .ref_hit   (ref_hot[g]),
            .ref_wr    (ref_write),
            .snp_hit   (snp_hot[g]),
            .fdone_hit (done_hot[g] && !done_own),
            .odone_hit (done_hot[g] && done_own),
            .shared_in (shared_in),
            .upd_en    (upd_en[g]),
            .inval     (inval[g]),
            .shr       (shr_vec[g]),
            .bus_req   (req_vec[g]),
            .vld       (line_vld[g]),
            .modf      (line_mod[g])
        );
    end

    assign shared_out  = |shr_vec;
    assign bus_upd_req = |req_vec;
endmodule

// File: rtl/upd_inv_ctrl_chk.sv
module upd_inv_ctrl_chk #(
    parameter int NUM_LINES = 4,
    parameter int IDX_W     = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fill_vld,
    input logic [IDX_W-1:0]     fill_idx,
    input logic                 ref_vld,
    input logic [IDX_W-1:0]     ref_idx,
    input logic                 ref_write,
    input logic                 snp_vld,
    input logic                 done_vld,
    input logic                 done_own,
    input logic                 shared_in,
    input logic                 shared_out,
    input logic                 bus_upd_req,
    input logic [NUM_LINES-1:0] upd_en,
    input logic [NUM_LINES-1:0] inval,
    input logic [NUM_LINES-1:0] line_vld,
    input logic [NUM_LINES-1:0] line_mod
);
    p_reset_empty_r1: assert property (@(posedge clk)
        !rst_n |=> (line_vld == '0));

    p_fill_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_vld |=> line_vld[$past(fill_idx)] && !line_mod[$past(fill_idx)]);

    p_shared_needs_snoop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        shared_out |-> snp_vld);

    p_inval_drops_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inval != '0) |=> ((line_vld & $past(inval)) == '0));

    p_upd_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en != '0) |-> (snp_vld && $onehot0(upd_en)));

    p_private_after_own_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((line_mod & ~$past(line_mod)) != '0) |-> $past(done_vld && done_own && !shared_in));

    p_mod_write_local_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_vld && ref_write && line_mod[ref_idx] && !fill_vld) |-> !bus_upd_req);
endmodule

bind upd_inv_ctrl upd_inv_ctrl_chk #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fill_vld(fill_vld), .fill_idx(fill_idx),
    .ref_vld(ref_vld), .ref_idx(ref_idx), .ref_write(ref_write),
    .snp_vld(snp_vld), .done_vld(done_vld), .done_own(done_own),
    .shared_in(shared_in), .shared_out(shared_out), .bus_upd_req(bus_upd_req),
    .upd_en(upd_en), .inval(inval), .line_vld(line_vld), .line_mod(line_mod));

// File: tb/upd_inv_ctrl_bench.sv
module upd_inv_ctrl_bench;
    localparam int N  = 4;
    localparam int TH = 3;
    localparam int IW = 2;

    logic clk = 0;
    logic rst_n = 0;
    logic cfg_defer, fill_vld, ref_vld, ref_write, snp_vld, done_vld, done_own, shared_in;
    logic [IW-1:0] fill_idx, ref_idx, snp_idx, done_idx;
    logic shared_out, bus_upd_req;
    logic [N-1:0] upd_en, inval, line_vld, line_mod;

    always #5 clk = ~clk;

    upd_inv_ctrl #(.NUM_LINES(N), .THRESH(TH)) u_upd_inv_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_defer(cfg_defer),
        .fill_vld(fill_vld), .fill_idx(fill_idx),
        .ref_vld(ref_vld), .ref_idx(ref_idx), .ref_write(ref_write),
        .snp_vld(snp_vld), .snp_idx(snp_idx),
        .done_vld(done_vld), .done_idx(done_idx), .done_own(done_own),
        .shared_in(shared_in), .shared_out(shared_out), .bus_upd_req(bus_upd_req),
        .upd_en(upd_en), .inval(inval), .line_vld(line_vld), .line_mod(line_mod));

    typedef struct {
        string        req;
        logic         shr;
        logic [N-1:0] upd;
        logic [N-1:0] inv;
        logic         bus;
        logic [N-1:0] vld;
        logic [N-1:0] mdf;
    } exp_t;

    exp_t sb_q[$];
    int checks = 0;
    int errors = 0;
    logic [N-1:0] ev = '0;
    logic [N-1:0] em = '0;

    task automatic chk(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic clr(logic defer);
        cfg_defer = defer; fill_vld = 0; fill_idx = '0; ref_vld = 0; ref_idx = '0;
        ref_write = 0; snp_vld = 0; snp_idx = '0; done_vld = 0; done_idx = '0;
        done_own = 0; shared_in = 0;
    endtask

    // Driver: applies one cycle of stimulus and queues the expectation.
    task automatic go(string req, logic defer, logic fv, int fi, logic rv, int ri, logic rw,
                      logic sv, int si, logic dv, int di, logic down, logic shin,
                      logic e_shr, logic [N-1:0] e_upd, logic [N-1:0] e_inv, logic e_bus);
        exp_t it;
        @(negedge clk);
        cfg_defer = defer; fill_vld = fv; fill_idx = IW'(fi);
        ref_vld = rv; ref_idx = IW'(ri); ref_write = rw;
        snp_vld = sv; snp_idx = IW'(si);
        done_vld = dv; done_idx = IW'(di); done_own = down; shared_in = shin;
        it.req = req; it.shr = e_shr; it.upd = e_upd; it.inv = e_inv; it.bus = e_bus;
        it.vld = ev; it.mdf = em;
        sb_q.push_back(it);
    endtask

    // Monitor: compares combinational outputs mid-cycle and state after the edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                chk(it.req, "shared_out", N'(shared_out), N'(it.shr));
                chk(it.req, "upd_en", upd_en, it.upd);
                chk(it.req, "inval", inval, it.inv);
                chk(it.req, "bus_upd_req", N'(bus_upd_req), N'(it.bus));
                @(posedge clk);
                #1;
                chk(it.req, "line_vld", line_vld, it.vld);
                chk(it.req, "line_mod", line_mod, it.mdf);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        clr(0);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1 reset state
        go("R1", 0, 0,0, 0,0,0, 0,0, 0,0,0,0, 0, 4'b0000, 4'b0000, 0);
        // R2 fills in immediate mode
        ev = 4'b0001; go("R2", 0, 1,0, 0,0,0, 0,0, 0,0,0,0, 0, 4'b0000, 4'b0000, 0);
        ev = 4'b0011; go("R2", 0, 1,1, 0,0,0, 0,0, 0,0,0,0, 0, 4'b0000, 4'b0000, 0);
        // R6 R7 three surviving snoops on line 0 (3->2->1->0)
        for (int k = 0; k < TH; k++)
            go("R6", 0, 0,0, 0,0,0, 1,0, 0,0,0,0, 1, 4'b0001, 4'b0000, 0);
        // R5 snoop at zero invalidates
        ev = 4'b0010; go("R5", 0, 0,0, 0,0,0, 1,0, 0,0,0,0, 0, 4'b0000, 4'b0001, 0);
        // R7 snoop to an invalid line raises nothing
        go("R7", 0, 0,0, 0,0,0, 1,0, 0,0,0,0, 0, 4'b0000, 4'b0000, 0);
        // Line 1 walked to zero
        for (int k = 0; k < TH; k++)
            go("R3", 0, 0,0, 0,0,0, 1,1, 0,0,0,0, 1, 4'b0010, 4'b0000, 0);
        // R4 reference with snoop at zero: reload wins, no kill
        go("R4", 0, 0,0, 1,1,0, 1,1, 0,0,0,0, 1, 4'b0010, 4'b0000, 0);
        for (int k = 0; k < TH; k++)
            go("R4", 0, 0,0, 0,0,0, 1,1, 0,0,0,0, 1, 4'b0010, 4'b0000, 0);
        ev = 4'b0000; go("R4", 0, 0,0, 0,0,0, 1,1, 0,0,0,0, 0, 4'b0000, 4'b0010, 0);
        // R11 references to an invalid line are ignored
        go("R11", 0, 0,0, 1,2,0, 0,0, 0,0,0,0, 0, 4'b0000, 4'b0000, 0);
        go("R11", 0, 0,0, 1,2,1, 0,0, 0,0,0,0, 0, 4'b0000, 4'b0000, 0);
        // R9 writer path on line 2
        ev = 4'b0100; go("R2", 0, 1,2, 0,0,0, 0,0, 0,0,0,0, 0, 4'b0000, 4'b0000, 0);
        go("R9", 0, 0,0, 1,2,1, 0,0, 0,0,0,0, 0, 4'b0000, 4'b0000, 1);
        go("R9", 0, 0,0, 0,0,0, 0,0, 1,2,1,1, 0, 4'b0000, 4'b0000, 0);
        go("R9", 0, 0,0, 1,2,1, 0,0, 0,0,0,0, 0, 4'b0000, 4'b0000, 1);
        em = 4'b0100; go("R9", 0, 0,0, 0,0,0, 0,0, 1,2,1,0, 0, 4'b0000, 4'b0000, 0);
        // R10 private writes stay local
        go("R10", 0, 0,0, 1,2,1, 0,0, 0,0,0,0, 0, 4'b0000, 4'b0000, 0);
        go("R10", 0, 0,0, 1,2,0, 0,0, 0,0,0,0, 0, 4'b0000, 4'b0000, 0);
        // R11 snoop on modified line: update and back to shared (count 3->2)
        em = 4'b0000; go("R11", 0, 0,0, 0,0,0, 1,2, 0,0,0,0, 1, 4'b0100, 4'b0000, 0);
        // Deferred mode: R2 fill with same-cycle snoop has no snoop effect
        ev = 4'b1100; go("R2", 1, 1,3, 0,0,0, 1,3, 0,0,0,0, 0, 4'b0000, 4'b0000, 0);
        // R3 counter reads back as THRESH through the shared line
        go("R3", 1, 0,0, 0,0,0, 1,3, 0,0,0,0, 1, 4'b1000, 4'b0000, 0);
        go("R3", 1, 0,0, 0,0,0, 1,3, 0,0,0,0, 1, 4'b1000, 4'b0000, 0);
        go("R3", 1, 0,0, 0,0,0, 1,3, 0,0,0,0, 0, 4'b1000, 4'b0000, 0);
        // R8 completion with shared high: nothing
        go("R8", 1, 0,0, 0,0,0, 0,0, 1,3,0,1, 0, 4'b0000, 4'b0000, 0);
        // R3 saturation: snoop at zero keeps updating, no kill in deferred mode
        go("R3", 1, 0,0, 0,0,0, 1,3, 0,0,0,0, 0, 4'b1000, 4'b0000, 0);
        // R8 completion with shared low kills the idle copy
        ev = 4'b0100; go("R8", 1, 0,0, 0,0,0, 0,0, 1,3,0,0, 0, 4'b0000, 4'b1000, 0);
        // Line 2 (count 2): 2->1, 1->0, then reload with snoop
        go("R3", 1, 0,0, 0,0,0, 1,2, 0,0,0,0, 1, 4'b0100, 4'b0000, 0);
        go("R3", 1, 0,0, 0,0,0, 1,2, 0,0,0,0, 0, 4'b0100, 4'b0000, 0);
        go("R4", 1, 0,0, 1,2,0, 1,2, 0,0,0,0, 1, 4'b0100, 4'b0000, 0);
        // R8 non-zero counter survives a low completion
        go("R8", 1, 0,0, 0,0,0, 0,0, 1,2,0,0, 0, 4'b0000, 4'b0000, 0);
        // R9 writer goes private in deferred mode
        go("R9", 1, 0,0, 1,2,1, 0,0, 0,0,0,0, 0, 4'b0000, 4'b0000, 1);
        em = 4'b0100; go("R9", 1, 0,0, 0,0,0, 0,0, 1,2,1,0, 0, 4'b0000, 4'b0000, 0);
        go("R10", 1, 0,0, 1,2,1, 0,0, 0,0,0,0, 0, 4'b0000, 4'b0000, 0);
        go("R1", 1, 0,0, 0,0,0, 0,0, 0,0,0,0, 0, 4'b0000, 4'b0000, 0);
        repeat (4) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule